// File: doc/BRIEF.md
# Memory Write-Calibration Sequencer

This block trains the write timing of a memory interface whose memory has no training register. The only way to judge a write delay setting is to read data back and see whether a known pattern returns intact. The sequencer owns two sets of delay taps. One delay moves the byte lane that carries the write clock. The other is a bank of per-lane delays for the remaining byte lanes. Before every probe it restarts an external read-alignment engine and waits for that engine to finish. It then takes the engine's per-lane pass/fail result as the verdict on the current write setting. Any mismatch is blamed on the write path.

The calibration runs in three sweeps. First, the clock-lane delay climbs from tap 0 until the clock lane passes; that tap is the left edge. Second, with the clock lane held at the left edge, each other lane's delay climbs from 0 until that lane passes. Third, the clock-lane delay climbs again until any lane fails; the tap before the failure is the common right edge. The clock-lane delay is then walked down to the middle of the window.

Calibration is skipped when it is disabled or when the memory clock is below the speed that needs it. In that case the block reports done with every tap at 0.

Top module: `wcal_seq`

## Requirements
- R1: After `init_done`, if `cal_enable` or `fast_clk` is low, `cal_done` goes high within 3 cycles with every tap at 0, `cal_err` low and no `ra_restart` pulse.
- R2: While `init_done` has not yet been high since reset, `ra_restart` and `cal_done` stay low.
- R3: Every `ra_restart` pulse comes at least max(16, `settle_cycles`) cycles after the last change of any tap output, or after reset.
- R4: Each probe gives exactly one single-cycle `ra_restart` pulse. The taps stay unchanged until `ra_done` ends the probe, and a probe is judged only on `ra_done`.
- R5: In the left-edge sweep, the first probe is at clock tap 0. Every probe in which `ra_pass[0]` is low is followed by a probe one clock tap higher. The first passing tap is recorded as the left edge.
- R6: If the clock lane passes on the first probe, the left edge is tap 0.
- R7: With the clock tap held at the left edge, lanes 1 to N_LANES are aligned in ascending order. Lane k's tap (`lane_tap[(k-1)*TAP_W +: TAP_W]`) rises one per failing probe (`ra_pass[k]` low) from 0, and stops at the first probe where `ra_pass[k]` is high.
- R8: After alignment, the clock tap rises one per probe while all `ra_pass` bits are high. The right edge is the tap just below the first probe with any bit low.
- R9: After the right edge is found, the clock tap falls by exactly one per cycle to floor((left+right)/2). `cal_done` then rises and the lane taps keep their aligned values.
- R10: If any sweep needs a tap beyond 2^TAP_W-1 (63 by default), `cal_err` rises, `cal_done` stays low and no further probe starts.
- R11: `cal_done` and `cal_err` each stay high until reset once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_enable | input | 1 | Write calibration enabled |
| fast_clk | input | 1 | Memory clock is at or above the speed that needs write calibration |
| init_done | input | 1 | Memory initialization and fixed-pattern read calibration complete |
| settle_cycles | input | SETTLE_W | Settle wait after a tap change; values below 16 are treated as 16 |
| ra_done | input | 1 | Read-alignment engine finished the current probe |
| ra_pass | input | N_LANES+1 | Per-lane pattern match; bit 0 is the clock lane |
| ra_restart | output | 1 | One-cycle reset-and-restart of the read-alignment engine |
| clk_tap | output | TAP_W | Clock-lane delay tap |
| lane_tap | output | N_LANES*TAP_W | Per-lane delay taps of the non-clock lanes, lane 1 in the low bits |
| cal_done | output | 1 | Calibration finished successfully (or bypassed) |
| cal_err | output | 1 | Calibration aborted at a tap limit |

## Verification
The assertions assume that the read-alignment engine raises `ra_done` only after a restart request, and only once per request. They also assume that `ra_pass` is meaningful only in the cycle `ra_done` is high, and that `init_done` is held high once raised. The bench stub answers each `ra_restart` with a single `ra_done` pulse three cycles later. It derives `ra_pass` from the tap outputs then visible and a configured window per lane. It keeps `init_done` and the configuration stable for a whole calibration and changes them only under reset.

// File: rtl/wcal_pkg.sv
package wcal_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_KICK,
      ST_WAIT,
      ST_CENTER,
      ST_DONE,
      ST_FAIL
   } wcal_state_e;

   typedef enum logic [1:0] {
      PH_LEFT,
      PH_ALIGN,
      PH_RIGHT
   } wcal_phase_e;

endpackage

// File: rtl/wcal_settle_timer.sv
module wcal_settle_timer #(
   parameter int SW         = 8,
   parameter int MIN_SETTLE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [SW-1:0] limit,
   output logic          expired
);
   localparam logic [SW-1:0] MIN_V = SW'(MIN_SETTLE);

   if (MIN_SETTLE < 1) begin : g_bad_min
      $error("MIN_SETTLE must be at least 1");
   end
   if (MIN_SETTLE >= (1 << SW)) begin : g_bad_sw
      $error("SW too narrow for MIN_SETTLE");
   end

   logic [SW-1:0] cnt_q;
   logic [SW-1:0] eff;

   always_comb begin
      eff     = (limit < MIN_V) ? MIN_V : limit;
      expired = run && (cnt_q == eff - SW'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt_q <= '0;
      else                cnt_q <= cnt_q + SW'(1);
   end
endmodule

// File: rtl/wcal_lane_taps.sv
module wcal_lane_taps #(
   parameter int NL = 3,
   parameter int TW = 6,
   parameter int IW = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [IW-1:0]    sel,
   output logic [NL*TW-1:0] taps,
   output logic [TW-1:0]    sel_tap
);
   for (genvar g = 0; g < NL; g++) begin : g_lane
      logic [TW-1:0] tap_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                       tap_q <= '0;
         else if (inc && sel == IW'(g))    tap_q <= tap_q + TW'(1);
      end
      assign taps[g*TW +: TW] = tap_q;
   end

   always_comb begin
      sel_tap = '0;
      for (int i = 0; i < NL; i++)
         if (sel == IW'(i)) sel_tap = taps[i*TW +: TW];
   end
endmodule

// File: rtl/wcal_center.sv
module wcal_center #(
   parameter int TW = 6
) (
   input  logic [TW-1:0] left,
   input  logic [TW-1:0] right,
   output logic [TW-1:0] center
);
   logic [TW:0] sum;
   always_comb begin
      sum    = {1'b0, left} + {1'b0, right};
      center = sum[TW:1];
   end
endmodule

// File: rtl/wcal_seq.sv
module wcal_seq
   import wcal_pkg::*;
#(
   parameter int N_LANES    = 3,
   parameter int TAP_W      = 6,
   parameter int SETTLE_W   = 8,
   parameter int MIN_SETTLE = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cal_enable,
   input  logic                     fast_clk,
   input  logic                     init_done,
   input  logic [SETTLE_W-1:0]      settle_cycles,
   input  logic                     ra_done,
   input  logic [N_LANES:0]         ra_pass,
   output logic                     ra_restart,
   output logic [TAP_W-1:0]         clk_tap,
   output logic [N_LANES*TAP_W-1:0] lane_tap,
   output logic                     cal_done,
   output logic                     cal_err
);
   localparam int            IW      = (N_LANES > 1) ? $clog2(N_LANES) : 1;
   localparam logic [TAP_W-1:0] TAP_TOP = '1;
   localparam logic [IW-1:0] LAST_IDX = IW'(N_LANES - 1);

   if (N_LANES < 1) begin : g_bad_lanes
      $error("N_LANES must be at least 1");
   end
   if (TAP_W < 2) begin : g_bad_tapw
      $error("TAP_W must be at least 2");
   end

   wcal_state_e      state_q;
   wcal_phase_e      phase_q;
   logic [TAP_W-1:0] clk_tap_q, left_q, right_q, center;
   logic [IW-1:0]    lane_idx_q;
   logic [TAP_W-1:0] sel_tap;
   logic             lane_ok, lane_inc, settle_exp, waiting;

   wcal_settle_timer #(.SW(SETTLE_W), .MIN_SETTLE(MIN_SETTLE)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_SETTLE),
      .limit   (settle_cycles),
      .expired (settle_exp)
   );

   wcal_lane_taps #(.NL(N_LANES), .TW(TAP_W), .IW(IW)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (lane_inc),
      .sel     (lane_idx_q),
      .taps    (lane_tap),
      .sel_tap (sel_tap)
   );

   wcal_center #(.TW(TAP_W)) u_center (
      .left   (left_q),
      .right  (right_q),
      .center (center)
   );

   always_comb begin
      lane_ok = 1'b0;
      for (int i = 0; i < N_LANES; i++)
         if (lane_idx_q == IW'(i)) lane_ok = ra_pass[i+1];
      waiting  = (state_q == ST_WAIT);
      lane_inc = waiting && ra_done && (phase_q == PH_ALIGN) &&
                 !lane_ok && (sel_tap != TAP_TOP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         phase_q    <= PH_LEFT;
         clk_tap_q  <= '0;
         left_q     <= '0;
         right_q    <= '0;
         lane_idx_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (init_done) begin
                  if (cal_enable && fast_clk) begin
                     state_q <= ST_SETTLE;
                     phase_q <= PH_LEFT;
                  end else begin
                     state_q <= ST_DONE;
                  end
               end
            end
            ST_SETTLE: if (settle_exp) state_q <= ST_KICK;
            ST_KICK:   state_q <= ST_WAIT;
            ST_WAIT: begin
               if (ra_done) begin
                  unique case (phase_q)
                     PH_LEFT: begin
                        if (ra_pass[0]) begin
                           left_q     <= clk_tap_q;
                           phase_q    <= PH_ALIGN;
                           lane_idx_q <= '0;
                           state_q    <= ST_SETTLE;
                        end else if (clk_tap_q == TAP_TOP) begin
                           state_q <= ST_FAIL;
                        end else begin
                           clk_tap_q <= clk_tap_q + TAP_W'(1);
                           state_q   <= ST_SETTLE;
                        end
                     end
                     PH_ALIGN: begin
                        if (lane_ok) begin
                           if (lane_idx_q == LAST_IDX) begin
                              phase_q <= PH_RIGHT;
                              if (clk_tap_q == TAP_TOP) begin
                                 state_q <= ST_FAIL;
                              end else begin
                                 clk_tap_q <= clk_tap_q + TAP_W'(1);
                                 state_q   <= ST_SETTLE;
                              end
                           end else begin
                              lane_idx_q <= lane_idx_q + IW'(1);
                              state_q    <= ST_SETTLE;
                           end
                        end else if (sel_tap == TAP_TOP) begin
                           state_q <= ST_FAIL;
                        end else begin
                           state_q <= ST_SETTLE;
                        end
                     end
                     PH_RIGHT: begin
                        if (&ra_pass) begin
                           if (clk_tap_q == TAP_TOP) begin
                              state_q <= ST_FAIL;
                           end else begin
                              clk_tap_q <= clk_tap_q + TAP_W'(1);
                              state_q   <= ST_SETTLE;
                           end
                        end else begin
                           right_q <= clk_tap_q - TAP_W'(1);
                           state_q <= ST_CENTER;
                        end
                     end
                     default: state_q <= ST_FAIL;
                  endcase
               end
            end
            ST_CENTER: begin
               if (clk_tap_q == center) state_q   <= ST_DONE;
               else                     clk_tap_q <= clk_tap_q - TAP_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign ra_restart = (state_q == ST_KICK);
   assign clk_tap    = clk_tap_q;
   assign cal_done   = (state_q == ST_DONE);
   assign cal_err    = (state_q == ST_FAIL);
endmodule

// File: rtl/wcal_seq_chk.sv
module wcal_seq_chk #(
   parameter int NL         = 3,
   parameter int TW         = 6,
   parameter int MIN_SETTLE = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             init_done,
   input logic             waiting,
   input logic             ra_restart,
   input logic [TW-1:0]    clk_tap,
   input logic [NL*TW-1:0] lane_tap,
   input logic             cal_done,
   input logic             cal_err
);
   localparam logic [TW-1:0] ONE = TW'(1);

   logic             seen_init;
   logic [15:0]      gap;
   logic [TW-1:0]    prev_clk;
   logic [NL*TW-1:0] prev_lane;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_init <= 1'b0;
         gap       <= '0;
         prev_clk  <= '0;
         prev_lane <= '0;
      end else begin
         if (init_done) seen_init <= 1'b1;
         prev_clk  <= clk_tap;
         prev_lane <= lane_tap;
         if (clk_tap != prev_clk || lane_tap != prev_lane) gap <= '0;
         else if (gap != 16'hFFFF)                         gap <= gap + 16'd1;
      end
   end

   AST_QUIET_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_init |-> (!ra_restart && !cal_done)); // R2

   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ra_restart |-> (gap >= 16'(MIN_SETTLE - 1))); // R3

   AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ra_restart |=> !ra_restart); // R4

   AST_TAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (waiting && $past(waiting)) |-> ($stable(clk_tap) && $stable(lane_tap))); // R4

   AST_CLK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_tap != $past(clk_tap)) |->
         ((clk_tap == $past(clk_tap) + ONE) || (clk_tap == $past(clk_tap) - ONE))); // R5

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cal_done |=> cal_done); // R11

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cal_err |=> (cal_err && !cal_done)); // R11
endmodule

bind wcal_seq wcal_seq_chk #(
   .NL(N_LANES), .TW(TAP_W), .MIN_SETTLE(MIN_SETTLE)
) u_wcal_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init_done  (init_done),
   .waiting    (waiting),
   .ra_restart (ra_restart),
   .clk_tap    (clk_tap),
   .lane_tap   (lane_tap),
   .cal_done   (cal_done),
   .cal_err    (cal_err)
);

// File: tb/tb_wcal_seq.sv
`timescale 1ns/1ps
module tb_wcal_seq;
   localparam int NL = 3;
   localparam int TW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cal_enable = 1'b0, fast_clk = 1'b0, init_done = 1'b0;
   logic [7:0]      settle_cycles = 8'd0;
   logic            ra_done = 1'b0;
   logic [NL:0]     ra_pass = '0;
   logic            ra_restart;
   logic [TW-1:0]   clk_tap;
   logic [NL*TW-1:0] lane_tap;
   logic            cal_done, cal_err;

   always #4 clk = ~clk;

   wcal_seq dut (
      .clk(clk), .rst_n(rst_n), .cal_enable(cal_enable), .fast_clk(fast_clk),
      .init_done(init_done), .settle_cycles(settle_cycles), .ra_done(ra_done),
      .ra_pass(ra_pass), .ra_restart(ra_restart), .clk_tap(clk_tap),
      .lane_tap(lane_tap), .cal_done(cal_done), .cal_err(cal_err)
   );

   int checks = 0, failures = 0, cyc = 0;
   bit finished = 0;

   // window configuration of the memory stub
   int lo0, hi0;
   int need[NL];
   int rlim[NL];
   int eff_settle;

   // reference probe list
   int    q_clk[$];
   logic [NL*TW-1:0] q_lane[$];
   string q_req[$];
   int    exp_left, exp_right, exp_center;
   bit    exp_err;
   int    restarts, gap, dly;
   logic [TW-1:0]    pclk;
   logic [NL*TW-1:0] plane;
   logic  prev_rs;

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic logic [NL:0] pass_of(int c, int l[NL]);
      logic [NL:0] v;
      v[0] = (c >= lo0) && (c <= hi0);
      for (int k = 0; k < NL; k++) v[k+1] = (l[k] >= need[k]) && (c <= rlim[k]);
      return v;
   endfunction

   function automatic logic [NL*TW-1:0] pack(int l[NL]);
      logic [NL*TW-1:0] v;
      for (int k = 0; k < NL; k++) v[k*TW +: TW] = TW'(l[k]);
      return v;
   endfunction

   task automatic push(int c, int l[NL], string req);
      q_clk.push_back(c);
      q_lane.push_back(pack(l));
      q_req.push_back(req);
   endtask

   task automatic build_model();
      int c;
      int l[NL];
      logic [NL:0] pv;
      q_clk.delete(); q_lane.delete(); q_req.delete();
      exp_err = 0;
      c = 0;
      for (int k = 0; k < NL; k++) l[k] = 0;
      forever begin
         push(c, l, "R5");
         pv = pass_of(c, l);
         if (pv[0]) break;
         if (c == 63) begin exp_err = 1; return; end
         c++;
      end
      exp_left = c;
      for (int k = 0; k < NL; k++) begin
         forever begin
            push(c, l, "R7");
            pv = pass_of(c, l);
            if (pv[k+1]) break;
            if (l[k] == 63) begin exp_err = 1; return; end
            l[k]++;
         end
      end
      forever begin
         if (c == 63) begin exp_err = 1; return; end
         c++;
         push(c, l, "R8");
         pv = pass_of(c, l);
         if (!(&pv)) break;
      end
      exp_right  = c - 1;
      exp_center = (exp_left + exp_right) / 2;
   endtask

   // read-alignment engine stub
   always @(negedge clk) begin
      ra_done = 1'b0;
      if (!rst_n) dly = 0;
      else if (dly > 0) begin
         dly--;
         if (dly == 0) begin
            int l[NL];
            for (int k = 0; k < NL; k++) l[k] = int'(lane_tap[k*TW +: TW]);
            ra_pass = pass_of(int'(clk_tap), l);
            ra_done = 1'b1;
         end
      end
      if (rst_n && ra_restart) dly = 3;
   end

   // per-clock comparison with the reference model
   always @(negedge clk) begin
      if (!rst_n) begin
         gap = 0; pclk = '0; plane = '0; prev_rs = 0;
      end else begin
         if (clk_tap != pclk || lane_tap != plane) gap = 0;
         else gap++;
         if (ra_restart) begin
            restarts++;
            check(gap >= eff_settle, "R3", "settle gap", gap, eff_settle);
            check(!prev_rs, "R4", "restart width", 2, 1);
            if (q_clk.size() == 0) begin
               check(0, "R4", "unexpected probe", restarts, 0);
            end else begin
               int    ec;
               logic [NL*TW-1:0] el;
               string rq;
               ec = q_clk.pop_front(); el = q_lane.pop_front(); rq = q_req.pop_front();
               check(int'(clk_tap) == ec, rq, "probe clock tap", int'(clk_tap), ec);
               check(lane_tap == el, rq, "probe lane taps", int'(lane_tap), int'(el));
            end
         end
         if (q_clk.size() == 0 && !cal_done && !cal_err && clk_tap != pclk && !exp_err)
            check(int'(clk_tap) == int'(pclk) - 1, "R9", "centering step",
                  int'(clk_tap), int'(pclk) - 1);
         prev_rs = ra_restart;
         pclk = clk_tap; plane = lane_tap;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !finished) begin
         finished = 1;
         failures++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run_case(string name, bit en, bit fast, int st, int l0, int h0,
                           int n0, int n1, int n2, int r0, int r1, int r2);
      int waitc;
      cal_enable = en; fast_clk = fast; settle_cycles = 8'(st);
      eff_settle = (st < 16) ? 16 : st;
      lo0 = l0; hi0 = h0;
      need[0] = n0; need[1] = n1; need[2] = n2;
      rlim[0] = r0; rlim[1] = r1; rlim[2] = r2;
      init_done = 0; rst_n = 0; restarts = 0;
      if (en && fast) build_model();
      else begin q_clk.delete(); q_lane.delete(); q_req.delete(); exp_err = 0; end
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(cal_done == 0 && cal_err == 0 && clk_tap == 0 && lane_tap == 0,
            "R11", {name, " reset state"}, int'(cal_done), 0);
      repeat (30) @(negedge clk);
      check(restarts == 0 && !cal_done, "R2", {name, " quiet before init"}, restarts, 0);
      init_done = 1;
      if (!(en && fast)) begin
         repeat (3) @(negedge clk);
         check(cal_done == 1 && cal_err == 0, "R1", {name, " bypass done"}, int'(cal_done), 1);
         check(clk_tap == 0 && lane_tap == 0, "R1", {name, " bypass taps"},
               int'(clk_tap) + int'(lane_tap), 0);
         repeat (20) @(negedge clk);
         check(restarts == 0, "R1", {name, " bypass no probe"}, restarts, 0);
         return;
      end
      waitc = 0;
      while (!cal_done && !cal_err && waitc < 60000) begin
         @(negedge clk); waitc++;
      end
      repeat (20) @(negedge clk);
      check(q_clk.size() == 0, "R4", {name, " all probes issued"}, q_clk.size(), 0);
      if (exp_err) begin
         check(cal_err == 1 && cal_done == 0, "R10", {name, " error flag"}, int'(cal_err), 1);
         check(dly == 0 && !ra_restart, "R10", {name, " no probe after error"}, dly, 0);
      end else begin
         int l[NL];
         for (int k = 0; k < NL; k++) l[k] = need[k];
         check(cal_done == 1 && cal_err == 0, "R11", {name, " done flag held"}, int'(cal_done), 1);
         check(int'(clk_tap) == exp_center, "R9", {name, " centre tap"}, int'(clk_tap), exp_center);
         check(lane_tap == pack(l), "R7", {name, " lane taps kept"}, int'(lane_tap), int'(pack(l)));
      end
   endtask

   initial begin
      run_case("bypass_disabled", 0, 1, 20, 5, 40, 3, 0, 7, 30, 63, 35);
      run_case("bypass_slow", 1, 0, 20, 5, 40, 3, 0, 7, 30, 63, 35);
      run_case("normal", 1, 1, 20, 5, 40, 3, 0, 7, 30, 63, 35);
      run_case("left_at_zero", 1, 1, 4, 0, 20, 0, 0, 0, 63, 63, 63);
      check(exp_left == 0 && exp_center == 10, "R6", "left edge at tap 0", exp_center, 10);
      run_case("narrow_window", 1, 1, 16, 10, 10, 1, 2, 0, 63, 63, 63);
      run_case("left_missing", 1, 1, 16, 99, 120, 0, 0, 0, 63, 63, 63);
      run_case("right_missing", 1, 1, 16, 2, 63, 0, 0, 0, 63, 63, 63);
      run_case("lane_unalignable", 1, 1, 16, 3, 30, 0, 64, 0, 63, 63, 63);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule